// File: doc/BRIEF.md
# PC Card 16-bit Socket Cycle Sequencer

This block converts a one-word host request into the address, card-enable and strobe timing of a 16-bit PC Card socket. A request names a cycle kind, a direction, a socket address, a size and write data. The kinds are common memory, attribute memory, I/O and DMA. The block accepts the request with a ready/valid handshake. It then runs three phases: setup, active and hold. At the end of hold it returns the read data together with a one-clock done pulse.

The register-select line carries a different meaning for each cycle kind. For memory cycles it selects the attribute space. For I/O cycles it marks the cycle as I/O. For DMA cycles to a card that supports DMA it is the DMA acknowledge. In ATA mode it is forced inactive. The card-enable lanes follow one scheme for 16-bit cards and another for 8-bit cards. The card can stretch the active phase with its WAIT# input, which reaches the sequencer through a synchronizer. The block also gates the card reset output, which is floated unless the socket is ready for it.

Top module: `pcc_socket_seq`

## Requirements
- R1: `req_ready` is high only while no cycle is in progress. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle has ended, and is high again in the clock after the done pulse.
- R2: After acceptance the cycle runs three phases. Setup has address and card enables driven and all strobes high, for `cfg_setup` clocks. Active has one strobe low, for at least `cfg_active` clocks. Hold has the strobes high again, for `cfg_hold` clocks. A count of zero behaves as one.
- R3: Strobe decode uses kind codes 0 = common memory, 1 = attribute memory, 2 = I/O and 3 = DMA. Memory reads pull `oe_n` low and memory writes pull `we_n` low. I/O and DMA reads pull `iord_n` low, and I/O and DMA writes pull `iow_n` low. No more than one strobe is ever low. On a write, `sock_dout` carries the write data and `sock_doe` is high.
- R4: `reg_n` is low for attribute memory and for I/O cycles, and high for common memory cycles.
- R5: On a DMA cycle, `reg_n` acts as an active-low DMA acknowledge. It is low when `cfg_dma_capable` is set and high otherwise.
- R6: While `cfg_ata` is set, `reg_n` stays high for every cycle kind.
- R7: With a 16-bit card (`cfg_8bit` low), a word access pulls both `ce1_n` and `ce2_n` low. A byte access pulls `ce1_n` low when address bit 0 is 0, and `ce2_n` low when address bit 0 is 1.
- R8: With an 8-bit card (`cfg_8bit` high), only `ce1_n` goes low and `ce2_n` stays high. Address bit 0 is passed through on `sock_addr` to pick the byte.
- R9: While the synchronized WAIT# is low, the active phase does not end. Take the first clock edge at which `card_wait_n` is sampled high after being low. The strobe is released on the fourth clock edge after that edge, unless the minimum active count ends later.
- R10: `rsp_rdata` takes `sock_din` on the clock edge that ends the active phase. A later change on `sock_din` during hold does not alter it.
- R11: `rsp_done` is high for exactly one clock, the last clock of the hold phase.
- R12: `card_reset_oe` is high only when `card_present`, `sock_power_on` and `if_enable` are all high. While it is high, `card_reset` equals `reset_ctl` (active high). Otherwise `card_reset` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle, can accept a request |
| req_kind | input | 2 | Cycle kind: 0 common, 1 attribute, 2 I/O, 3 DMA |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (26) | Socket address |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_wdata | input | DW (16) | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DW (16) | Captured read data |
| cfg_setup | input | CW (4) | Setup clocks |
| cfg_active | input | CW (4) | Minimum active clocks |
| cfg_hold | input | CW (4) | Hold clocks |
| cfg_8bit | input | 1 | Card is 8-bit |
| cfg_ata | input | 1 | ATA mode, register-select forced high |
| cfg_dma_capable | input | 1 | Card accepts DMA acknowledge |
| card_wait_n | input | 1 | Card WAIT#, asynchronous |
| sock_din | input | DW (16) | Socket data in |
| sock_addr | output | AW (26) | Socket address |
| sock_dout | output | DW (16) | Socket data out |
| sock_doe | output | 1 | Socket data output enable |
| ce1_n | output | 1 | Even-byte card enable |
| ce2_n | output | 1 | Odd-byte card enable |
| oe_n | output | 1 | Memory read strobe |
| we_n | output | 1 | Memory write strobe |
| iord_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| reg_n | output | 1 | Register select / I/O marker / DMA acknowledge |
| card_present | input | 1 | Card detected |
| sock_power_on | input | 1 | Socket power applied |
| if_enable | input | 1 | Socket interface outputs enabled |
| reset_ctl | input | 1 | Card reset control bit |
| card_reset | output | 1 | Card reset value |
| card_reset_oe | output | 1 | Card reset driver enable |

## Verification
Two functions can coincide on the same clock edge: capturing the read data and releasing the strobe. The bench drives a known value on the socket data bus during active. It flips that value in the first hold cycle and expects the done pulse to return the earlier value. A second overlap is between the end of the WAIT# stretch and the end of the minimum active count. The bench holds WAIT# low across the whole minimum count, releases it at a known active clock, and expects an exact active length that only the synchronizer delay explains.

// File: rtl/pcc_seq_pkg.sv
package pcc_seq_pkg;

  typedef enum logic [1:0] {
    K_COMMON = 2'd0,
    K_ATTR   = 2'd1,
    K_IO     = 2'd2,
    K_DMA    = 2'd3
  } pcc_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } pcc_phase_e;

  // Level of the register-select line for a cycle kind (1 = inactive).
  function automatic logic reg_level(pcc_kind_e kind, logic ata, logic dma_cap);
    logic lvl;
    if (ata) lvl = 1'b1;
    else begin
      case (kind)
        K_ATTR:  lvl = 1'b0;
        K_IO:    lvl = 1'b0;
        K_DMA:   lvl = ~dma_cap;
        default: lvl = 1'b1;
      endcase
    end
    return lvl;
  endfunction

  // Card-enable levels {ce2_n, ce1_n} for the chosen lane scheme.
  function automatic logic [1:0] lane_levels(logic narrow, logic word, logic a0);
    logic [1:0] lv;
    if (narrow)    lv = 2'b10;
    else if (word) lv = 2'b00;
    else if (a0)   lv = 2'b01;
    else           lv = 2'b10;
    return lv;
  endfunction

  // Active-high strobe pick {iow, iord, we, oe}.
  function automatic logic [3:0] strobe_pick(pcc_kind_e kind, logic write);
    logic mem;
    mem = (kind == K_COMMON) || (kind == K_ATTR);
    return {~mem & write, ~mem & ~write, mem & write, mem & ~write};
  endfunction

endpackage

// File: rtl/pcc_wait_sync.sv
module pcc_wait_sync #(
  parameter int STAGES = 2,
  parameter int QUIET  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_n_async,
  output logic wait_released
);
  localparam int QW = $clog2(QUIET + 1);

  logic [STAGES-1:0] sync_q;
  logic [QW-1:0]     quiet_q;
  logic              wait_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], wait_n_async};
  end
  assign wait_n_s = sync_q[STAGES-1];

  // Counts clocks with the synchronized WAIT# high, saturating at QUIET.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     quiet_q <= QW'(QUIET);
    else if (!wait_n_s)             quiet_q <= '0;
    else if (quiet_q != QW'(QUIET)) quiet_q <= quiet_q + 1'b1;
  end
  assign wait_released = (quiet_q == QW'(QUIET));

  p_wait_blocks_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_n_s |=> !wait_released);

endmodule

// File: rtl/pcc_phase_ctrl.sv
module pcc_phase_ctrl
  import pcc_seq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len_setup,
  input  logic [CW-1:0] len_active,
  input  logic [CW-1:0] len_hold,
  input  logic          wait_released,
  output pcc_phase_e    phase,
  output logic          active_exit,
  output logic          done,
  output logic          idle
);
  // Index of the last clock in a phase; a zero length counts as one.
  function automatic logic [CW-1:0] last_idx(logic [CW-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  pcc_phase_e    phase_q;
  logic [CW-1:0] cnt_q;
  logic          setup_end, active_min_met;

  assign setup_end      = (phase_q == PH_SETUP) && (cnt_q == last_idx(len_setup));
  assign active_min_met = (cnt_q >= last_idx(len_active));
  assign active_exit    = (phase_q == PH_ACTIVE) && active_min_met && wait_released;
  assign done           = (phase_q == PH_HOLD) && (cnt_q == last_idx(len_hold));
  assign idle           = (phase_q == PH_IDLE);
  assign phase          = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_SETUP;
          cnt_q   <= '0;
        end
        PH_SETUP: if (setup_end) begin
          phase_q <= PH_ACTIVE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_ACTIVE: if (active_exit) begin
          phase_q <= PH_HOLD;
          cnt_q   <= '0;
        end else if (!active_min_met) cnt_q <= cnt_q + 1'b1;
        default: if (done) begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
      endcase
    end
  end

  p_wait_holds_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ACTIVE && !wait_released) |=> (phase_q == PH_ACTIVE));
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_setup_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETUP) |=> (phase_q == PH_SETUP || phase_q == PH_ACTIVE));
  p_hold_after_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active_exit |=> (phase_q == PH_HOLD));

endmodule

// File: rtl/pcc_strobe_decode.sv
module pcc_strobe_decode
  import pcc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pcc_phase_e phase,
  input  pcc_kind_e  kind,
  input  logic       write,
  input  logic       word,
  input  logic       a0,
  input  logic       narrow,
  input  logic       ata,
  input  logic       dma_cap,
  output logic       ce1_n,
  output logic       ce2_n,
  output logic       oe_n,
  output logic       we_n,
  output logic       iord_n,
  output logic       iow_n,
  output logic       reg_n
);
  logic       busy, strobing;
  logic [1:0] lanes;
  logic [3:0] pick;

  assign busy     = (phase != PH_IDLE);
  assign strobing = (phase == PH_ACTIVE);
  assign lanes    = lane_levels(narrow, word, a0);
  assign pick     = strobe_pick(kind, write);

  assign ce1_n  = busy ? lanes[0] : 1'b1;
  assign ce2_n  = busy ? lanes[1] : 1'b1;
  assign reg_n  = busy ? reg_level(kind, ata, dma_cap) : 1'b1;
  assign oe_n   = ~(strobing & pick[0]);
  assign we_n   = ~(strobing & pick[1]);
  assign iord_n = ~(strobing & pick[2]);
  assign iow_n  = ~(strobing & pick[3]);

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~oe_n, ~we_n, ~iord_n, ~iow_n}) <= 1);
  p_strobe_in_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(oe_n && we_n && iord_n && iow_n) |-> (phase == PH_ACTIVE));
  p_narrow_ce2_r8: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |-> ce2_n);
  p_ata_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ata |-> reg_n);

endmodule

// File: rtl/pcc_socket_seq.sv
module pcc_socket_seq
  import pcc_seq_pkg::*;
#(
  parameter int AW = 26,
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          req_word,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_active,
  input  logic [CW-1:0] cfg_hold,
  input  logic          cfg_8bit,
  input  logic          cfg_ata,
  input  logic          cfg_dma_capable,
  input  logic          card_wait_n,
  input  logic [DW-1:0] sock_din,
  output logic [AW-1:0] sock_addr,
  output logic [DW-1:0] sock_dout,
  output logic          sock_doe,
  output logic          ce1_n,
  output logic          ce2_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          iord_n,
  output logic          iow_n,
  output logic          reg_n,
  input  logic          card_present,
  input  logic          sock_power_on,
  input  logic          if_enable,
  input  logic          reset_ctl,
  output logic          card_reset,
  output logic          card_reset_oe
);
  pcc_kind_e     kind_q;
  logic          write_q, word_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          accept, wait_released, active_exit, done, idle;
  pcc_phase_e    phase;

  assign accept = req_valid && idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_COMMON;
      write_q <= 1'b0;
      word_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      kind_q  <= pcc_kind_e'(req_kind);
      write_q <= req_write;
      word_q  <= req_word;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rdata_q <= '0;
    else if (active_exit) rdata_q <= sock_din;
  end

  pcc_wait_sync #(.STAGES(2), .QUIET(2)) u_wait (
    .clk(clk), .rst_n(rst_n), .wait_n_async(card_wait_n),
    .wait_released(wait_released)
  );

  pcc_phase_ctrl #(.CW(CW)) u_phase (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .len_setup(cfg_setup), .len_active(cfg_active), .len_hold(cfg_hold),
    .wait_released(wait_released), .phase(phase),
    .active_exit(active_exit), .done(done), .idle(idle)
  );

  pcc_strobe_decode u_decode (
    .clk(clk), .rst_n(rst_n), .phase(phase), .kind(kind_q),
    .write(write_q), .word(word_q), .a0(addr_q[0]),
    .narrow(cfg_8bit), .ata(cfg_ata), .dma_cap(cfg_dma_capable),
    .ce1_n(ce1_n), .ce2_n(ce2_n), .oe_n(oe_n), .we_n(we_n),
    .iord_n(iord_n), .iow_n(iow_n), .reg_n(reg_n)
  );

  assign req_ready     = idle;
  assign rsp_done      = done;
  assign rsp_rdata     = rdata_q;
  assign sock_addr     = addr_q;
  assign sock_dout     = wdata_q;
  assign sock_doe      = write_q && (phase != PH_IDLE);
  assign card_reset_oe = card_present && sock_power_on && if_enable;
  assign card_reset    = card_reset_oe && reset_ctl;

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_reset_float_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !card_reset_oe |-> !card_reset);
  p_rdata_stable_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HOLD) |=> $stable(rsp_rdata));

endmodule

// File: tb/pcc_socket_seq_tb.sv
`timescale 1ns/1ps
module pcc_socket_seq_tb_top;
  localparam int AW = 26, DW = 16, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_word = 0;
  logic [1:0] req_kind = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0, sock_din = 0;
  logic [CW-1:0] cfg_setup = 1, cfg_active = 2, cfg_hold = 1;
  logic cfg_8bit = 0, cfg_ata = 0, cfg_dma_capable = 0, card_wait_n = 1;
  logic card_present = 0, sock_power_on = 0, if_enable = 0, reset_ctl = 0;
  logic req_ready, rsp_done, sock_doe, ce1_n, ce2_n, oe_n, we_n, iord_n, iow_n, reg_n;
  logic card_reset, card_reset_oe;
  logic [DW-1:0] rsp_rdata, sock_dout;
  logic [AW-1:0] sock_addr;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pcc_socket_seq #(.AW(AW), .DW(DW), .CW(CW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Result of one run
  int ns, na, nh, busy_ready;
  logic [3:0] str_n;
  logic rg, c1, c2, doe_s;
  logic [DW-1:0] rd, dout_s;
  bit got_done;

  task automatic run(input logic [1:0] kind, input logic wr, input logic [7:0] addr,
                     input logic word, input logic [DW-1:0] din, input int wait_rel,
                     input bit swap);
    ns = 0; na = 0; nh = 0; busy_ready = 0; got_done = 0;
    sock_din = din;
    @(negedge clk);
    req_kind = kind; req_write = wr; req_addr = AW'(addr); req_word = word;
    req_wdata = ~din; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    for (int i = 0; i < 300; i++) begin
      if (i > 0) @(negedge clk);
      if (req_ready) busy_ready++;
      if (!(oe_n && we_n && iord_n && iow_n)) begin
        na++;
        if (na == 1) begin
          str_n = {iow_n, iord_n, we_n, oe_n};
          rg = reg_n; c1 = ce1_n; c2 = ce2_n; doe_s = sock_doe; dout_s = sock_dout;
        end
        if (wait_rel > 0 && na == wait_rel) card_wait_n = 1;
      end else if (na == 0) ns++;
      else begin
        nh++;
        if (swap && nh == 1) sock_din = ~din;
      end
      if (rsp_done) begin
        rd = rsp_rdata; got_done = 1;
        break;
      end
    end
    chk(got_done, "R11 done seen", int'(got_done), 1);
    chk(busy_ready == 0, "R1 ready low while busy", busy_ready, 0);
    @(negedge clk);
    chk(!rsp_done, "R11 done one clock", int'(rsp_done), 0);
    chk(req_ready, "R1 ready after done", int'(req_ready), 1);
  endtask

  // {kind, wr, addr, word, b8, ata, dcap, exp strobes {iow,iord,we,oe}, reg, ce1, ce2}
  typedef logic [21:0] vec_t;
  localparam vec_t VECS [12] = '{
    {2'd0, 1'b0, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1110, 1'b1, 1'b0, 1'b0},
    {2'd0, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1101, 1'b1, 1'b1, 1'b0},
    {2'd1, 1'b0, 8'h20, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1110, 1'b0, 1'b0, 1'b1},
    {2'd2, 1'b1, 8'h30, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0111, 1'b0, 1'b0, 1'b0},
    {2'd2, 1'b0, 8'h31, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1011, 1'b0, 1'b1, 1'b0},
    {2'd3, 1'b0, 8'h40, 1'b1, 1'b0, 1'b0, 1'b1, 4'b1011, 1'b0, 1'b0, 1'b0},
    {2'd3, 1'b1, 8'h42, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0111, 1'b1, 1'b0, 1'b0},
    {2'd1, 1'b0, 8'h50, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1110, 1'b1, 1'b0, 1'b0},
    {2'd2, 1'b1, 8'h52, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0111, 1'b1, 1'b0, 1'b0},
    {2'd0, 1'b0, 8'h61, 1'b0, 1'b1, 1'b0, 1'b0, 4'b1110, 1'b1, 1'b0, 1'b1},
    {2'd0, 1'b0, 8'h62, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1110, 1'b1, 1'b0, 1'b1},
    {2'd2, 1'b1, 8'h64, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0111, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    // Reset state
    chk(req_ready, "R1 reset ready", int'(req_ready), 1);
    chk({oe_n, we_n, iord_n, iow_n} == 4'hF, "R3 reset strobes", {oe_n, we_n, iord_n, iow_n}, 15);
    chk(ce1_n && ce2_n && reg_n, "R7 reset enables", {ce1_n, ce2_n, reg_n}, 7);
    chk(!rsp_done, "R11 reset done", int'(rsp_done), 0);
    rst_n = 1;
    @(negedge clk);

    // Table walk
    foreach (VECS[i]) begin
      logic [1:0] k; logic w, wd, b8, at, dc, er, e1, e2; logic [7:0] ad; logic [3:0] es;
      logic [DW-1:0] din;
      string rtag, ctag;
      {k, w, ad, wd, b8, at, dc, es, er, e1, e2} = VECS[i];
      cfg_8bit = b8; cfg_ata = at; cfg_dma_capable = dc;
      din = {ad, ~ad};
      run(k, w, ad, wd, din, 0, 0);
      rtag = at ? "R6 reg" : (k == 2'd3) ? "R5 reg" : "R4 reg";
      ctag = b8 ? "R8 enables" : "R7 enables";
      chk(str_n == es, "R3 strobe", str_n, es);
      chk(rg == er, rtag, rg, er);
      chk({c1, c2} == {e1, e2}, ctag, {c1, c2}, {e1, e2});
      chk(ns == 1 && na == 2 && nh == 1, "R2 phases", ns * 100 + na * 10 + nh, 121);
      if (w) chk(doe_s && dout_s == ~din, "R3 write data", dout_s, ~din);
      else   chk(rd == din, "R10 read data", rd, din);
    end
    cfg_8bit = 0; cfg_ata = 0; cfg_dma_capable = 0;

    // Longer phase counts
    cfg_setup = 3; cfg_active = 4; cfg_hold = 2;
    run(2'd0, 0, 8'h02, 1, 16'h1234, 0, 0);
    chk(ns == 3 && na == 4 && nh == 2, "R2 long phases", ns * 100 + na * 10 + nh, 342);

    // Zero counts behave as one
    cfg_setup = 0; cfg_active = 0; cfg_hold = 0;
    run(2'd1, 1, 8'h04, 1, 16'h5678, 0, 0);
    chk(ns == 1 && na == 1 && nh == 1, "R2 zero counts", ns * 100 + na * 10 + nh, 111);

    // WAIT# stretch: released at the 6th active sample, strobe low for 10 clocks
    cfg_setup = 1; cfg_active = 2; cfg_hold = 1;
    card_wait_n = 0;
    repeat (4) @(negedge clk);
    run(2'd2, 0, 8'h06, 1, 16'h9ABC, 6, 0);
    chk(na == 10, "R9 wait stretch", na, 10);
    chk(rd == 16'h9ABC, "R10 read after wait", rd, 16'h9ABC);
    card_wait_n = 1;
    repeat (3) @(negedge clk);

    // Data changed in hold must not reach the result
    cfg_hold = 3;
    run(2'd0, 0, 8'h08, 1, 16'hC3A5, 0, 1);
    chk(rd == 16'hC3A5, "R10 capture before release", rd, 16'hC3A5);
    cfg_hold = 1;

    // Card reset gating
    reset_ctl = 1;
    for (int m = 0; m < 8; m++) begin
      bit en;
      {card_present, sock_power_on, if_enable} = 3'(m);
      en = (m == 7);
      @(negedge clk);
      chk(card_reset_oe == en, "R12 reset enable", card_reset_oe, en);
      chk(card_reset == en, "R12 reset value", card_reset, en);
    end
    reset_ctl = 0;
    @(negedge clk);
    chk(card_reset_oe && !card_reset, "R12 reset follows control", card_reset, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule